// File: doc/BRIEF.md
# UART Transmit Command Sequencer

This block is a serial transmitter that only sends while a command it has been given is running. Software loads characters into a small transmit FIFO, programs how many characters the next command should send, and then writes a command word whose top five bits carry the opcode. The engine pulls bytes from the FIFO one at a time. Each byte goes out as one start bit, eight data bits with the least significant bit first, and one stop bit. There is no parity. A clock divider paces the line at 32 clock ticks per bit for each divider step.

Progress is reported through a sticky interrupt status word. It has a command-done flag, an abort-done flag and a FIFO watermark flag, and each flag is cleared by writing a one to it. An enable mask selects which flags drive the single interrupt line. A control word can end a running command in three ways. Abort flushes the FIFO and raises the abort flag. Cancel raises the done flag. Disable stops silently.

Top module: `uart_tx_seq`

## Requirements
- R1: After reset, txd is high, irq is low, the engine status word (offset 0x18) reads 0, the FIFO count (offset 0x1C) reads 0, the watermark level (offset 0x20) reads 2, the interrupt enable word (offset 0x0C) reads 0, and the clock word (offset 0x24) reads 0x11.
- R2: Writing offset 0x00 with value 1 in bits 31:27, while the engine is idle and the length word (offset 0x04) is N>0, starts a command. The command sends N FIFO bytes. Status bit 0 is high while it runs. Done (interrupt status bit 0, offset 0x10) is set on the same edge on which status bit 0 drops, which is after the last stop bit. While no command runs, txd is high.
- R3: A frame is a low start bit, then eight data bits LSB first, then a high stop bit. Each bit lasts 32*D clocks, where D is clock word bits 15:4, and a value of 0 counts as 1.
- R4: While clock word bit 0 is 0, the bit timer holds and the line keeps its level.
- R5: A start command written while a command is running is ignored. A command word with any opcode other than 1 is ignored.
- R6: Writing offset 0x08 with bit 1 set ends any command, drives txd high on the next clock, empties the FIFO and sets interrupt status bit 5.
- R7: Writing offset 0x08 with bit 2 set ends a running command and sets done. Writing it with only bit 0 set ends a running command and sets no flag.
- R8: Interrupt status bit 30 is set on every clock in which the FIFO holds fewer words than the watermark level.
- R9: Writing a one to a bit of offset 0x14 clears that status bit. A bit whose set condition holds in the same cycle stays set.
- R10: irq is high exactly when some status bit among 0, 5 and 30 is set and its enable bit at the same position in offset 0x0C is set.
- R11: A write to offset 0x28 pushes bits 7:0 into the FIFO. A push into a full FIFO is dropped. Offset 0x1C reports the word count.
- R12: A start command with length 0 sets done at once and does not make the engine active.
- R13: If the FIFO runs dry during a command, the engine stays active with the line high, and it resumes when data arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| txd | output | 1 | Serial line |
| irq | output | 1 | Interrupt request |

## Verification
A wrong bit counter or divider count shows up on txd within one bit time. The bench checks the line on every clock against a behavioural model, so a start, data or stop bit that is one clock long or short is reported at that clock. A wrong remaining-character count or a stuck active flag shows up as done or the status bit changing on the wrong clock, and this is caught at the next status read or by the irq comparison on the next cycle. A FIFO pointer error appears as wrong data bits or a wrong word count in the character that follows.

// File: rtl/uatx_pkg.sv
package uatx_pkg;
   localparam int unsigned OVERSAMPLE = 32;

   localparam int unsigned A_CMD   = 'h00;
   localparam int unsigned A_LEN   = 'h04;
   localparam int unsigned A_CTRL  = 'h08;
   localparam int unsigned A_IEN   = 'h0C;
   localparam int unsigned A_ISTAT = 'h10;
   localparam int unsigned A_ICLR  = 'h14;
   localparam int unsigned A_STAT  = 'h18;
   localparam int unsigned A_FCNT  = 'h1C;
   localparam int unsigned A_WM    = 'h20;
   localparam int unsigned A_CLK   = 'h24;
   localparam int unsigned A_TXD   = 'h28;

   localparam int unsigned IB_DONE  = 0;
   localparam int unsigned IB_ABORT = 5;
   localparam int unsigned IB_WM    = 30;
   localparam logic [31:0] IRQ_MASK = (32'd1 << IB_DONE) | (32'd1 << IB_ABORT) | (32'd1 << IB_WM);

   localparam logic [4:0] OP_SEND = 5'd1;

   typedef enum logic [1:0] {SH_IDLE, SH_START, SH_DATA, SH_STOP} sh_state_e;
endpackage

// File: rtl/uatx_fifo.sv
module uatx_fifo #(
   parameter int unsigned DEPTH = 16,
   parameter int unsigned W     = 8,
   localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
   localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             flush,
   input  logic             push,
   input  logic [W-1:0]     wdata,
   input  logic             pop,
   output logic [W-1:0]     rdata,
   output logic [CNT_W-1:0] count
);
   if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("uatx_fifo: DEPTH must be a power of two of at least 2");
   end

   logic [W-1:0]     mem [DEPTH];
   logic [PTR_W-1:0] wp_q, rp_q;
   logic             push_ok, pop_ok;

   assign push_ok = push && (count < CNT_W'(DEPTH));
   assign pop_ok  = pop && (count != '0);
   assign rdata   = mem[rp_q];

   always_ff @(posedge clk) begin
      if (push_ok && !flush) mem[wp_q] <= wdata;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wp_q  <= '0;
         rp_q  <= '0;
         count <= '0;
      end else if (flush) begin
         wp_q  <= '0;
         rp_q  <= '0;
         count <= '0;
      end else begin
         if (push_ok) wp_q <= wp_q + PTR_W'(1);
         if (pop_ok)  rp_q <= rp_q + PTR_W'(1);
         count <= count + CNT_W'(push_ok) - CNT_W'(pop_ok);
      end
   end
endmodule

// File: rtl/uatx_shifter.sv
module uatx_shifter
   import uatx_pkg::*;
#(
   parameter int unsigned DIV_W = 12,
   localparam int unsigned OS_SH = $clog2(OVERSAMPLE),
   localparam int unsigned CNT_W = DIV_W + OS_SH
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick_en,
   input  logic [DIV_W-1:0] div,
   input  logic             load,
   input  logic [7:0]       din,
   input  logic             flush,
   output logic             txd,
   output logic             idle
);
   if ((OVERSAMPLE & (OVERSAMPLE - 1)) != 0) begin : g_bad_os
      $error("uatx_shifter: oversampling factor must be a power of two");
   end

   sh_state_e        st_q;
   logic [CNT_W-1:0] cnt_q, last;
   logic [DIV_W-1:0] div_eff;
   logic [2:0]       idx_q;
   logic [7:0]       sh_q;

   assign div_eff = (div == '0) ? DIV_W'(1) : div;
   assign last    = {div_eff, {OS_SH{1'b0}}} - CNT_W'(1);
   assign idle    = (st_q == SH_IDLE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q  <= SH_IDLE;
         cnt_q <= '0;
         idx_q <= '0;
         sh_q  <= '0;
         txd   <= 1'b1;
      end else if (flush) begin
         st_q  <= SH_IDLE;
         cnt_q <= '0;
         txd   <= 1'b1;
      end else if (load && idle) begin
         sh_q  <= din;
         st_q  <= SH_START;
         cnt_q <= '0;
         txd   <= 1'b0;
      end else if (!idle && tick_en) begin
         if (cnt_q == last) begin
            cnt_q <= '0;
            unique case (st_q)
               SH_START: begin
                  st_q  <= SH_DATA;
                  idx_q <= '0;
                  txd   <= sh_q[0];
               end
               SH_DATA: begin
                  if (idx_q == 3'd7) begin
                     st_q <= SH_STOP;
                     txd  <= 1'b1;
                  end else begin
                     idx_q <= idx_q + 3'd1;
                     txd   <= sh_q[idx_q + 3'd1];
                  end
               end
               default: st_q <= SH_IDLE;
            endcase
         end else begin
            cnt_q <= cnt_q + CNT_W'(1);
         end
      end
   end
endmodule

// File: rtl/uart_tx_seq.sv
module uart_tx_seq
   import uatx_pkg::*;
#(
   parameter int unsigned ADDR_W     = 8,
   parameter int unsigned FIFO_DEPTH = 16,
   parameter int unsigned LEN_W      = 16,
   parameter int unsigned WM_W       = 8,
   parameter int unsigned DIV_W      = 12,
   parameter int unsigned WM_RESET   = 2,
   localparam int unsigned CNT_W     = $clog2(FIFO_DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [31:0]       bus_wdata,
   output logic [31:0]       bus_rdata,
   output logic              txd,
   output logic              irq
);
   if (LEN_W > 27 || DIV_W > 12 || WM_W > 28 || ADDR_W < 6) begin : g_bad_cfg
      $error("uart_tx_seq: parameter out of range for the register layout");
   end

   logic [31:0]       cmd_q, ien_q, istat_q, irq_set;
   logic [LEN_W-1:0]  len_q, remain_q;
   logic [WM_W-1:0]   wm_q;
   logic [DIV_W-1:0]  div_q;
   logic              clk_en_q, active_q;
   logic              wr_cmd, wr_len, wr_ctrl, wr_ien, wr_iclr, wr_wm, wr_clk, wr_txd;
   logic              wr_abort, wr_cancel, stop_any, cmd_go, pop, done_evt, wm_hit;
   logic              sh_idle;
   logic [7:0]        fifo_head;
   logic [CNT_W-1:0]  fifo_cnt;

   assign wr_cmd  = bus_wr && (bus_addr == ADDR_W'(A_CMD));
   assign wr_len  = bus_wr && (bus_addr == ADDR_W'(A_LEN));
   assign wr_ctrl = bus_wr && (bus_addr == ADDR_W'(A_CTRL));
   assign wr_ien  = bus_wr && (bus_addr == ADDR_W'(A_IEN));
   assign wr_iclr = bus_wr && (bus_addr == ADDR_W'(A_ICLR));
   assign wr_wm   = bus_wr && (bus_addr == ADDR_W'(A_WM));
   assign wr_clk  = bus_wr && (bus_addr == ADDR_W'(A_CLK));
   assign wr_txd  = bus_wr && (bus_addr == ADDR_W'(A_TXD));

   assign stop_any  = wr_ctrl && (bus_wdata[2:0] != 3'b000);
   assign wr_abort  = wr_ctrl && bus_wdata[1];
   assign wr_cancel = wr_ctrl && bus_wdata[2];
   assign cmd_go    = wr_cmd && (bus_wdata[31:27] == OP_SEND) && !active_q;

   assign pop = active_q && !stop_any && sh_idle && (remain_q != '0) && (fifo_cnt != '0);
   assign done_evt = (active_q && !stop_any && sh_idle && (remain_q == '0))
                   || (cmd_go && (len_q == '0))
                   || (wr_cancel && active_q);
   assign wm_hit = 32'(fifo_cnt) < 32'(wm_q);

   always_comb begin
      irq_set = '0;
      irq_set[IB_DONE]  = done_evt;
      irq_set[IB_ABORT] = wr_abort;
      irq_set[IB_WM]    = wm_hit;
   end

   uatx_fifo #(.DEPTH(FIFO_DEPTH), .W(8)) u_fifo (
      .clk(clk), .rst_n(rst_n), .flush(wr_abort),
      .push(wr_txd), .wdata(bus_wdata[7:0]),
      .pop(pop), .rdata(fifo_head), .count(fifo_cnt)
   );

   uatx_shifter #(.DIV_W(DIV_W)) u_shift (
      .clk(clk), .rst_n(rst_n), .tick_en(clk_en_q), .div(div_q),
      .load(pop), .din(fifo_head), .flush(stop_any),
      .txd(txd), .idle(sh_idle)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active_q <= 1'b0;
         remain_q <= '0;
      end else if (stop_any) begin
         active_q <= 1'b0;
      end else if (cmd_go) begin
         if (len_q != '0) begin
            active_q <= 1'b1;
            remain_q <= len_q;
         end
      end else if (active_q && sh_idle) begin
         if (remain_q == '0)    active_q <= 1'b0;
         else if (fifo_cnt != '0) remain_q <= remain_q - LEN_W'(1);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cmd_q    <= '0;
         len_q    <= '0;
         ien_q    <= '0;
         istat_q  <= '0;
         wm_q     <= WM_W'(WM_RESET);
         div_q    <= DIV_W'(1);
         clk_en_q <= 1'b1;
      end else begin
         if (wr_cmd) cmd_q <= bus_wdata;
         if (wr_len) len_q <= bus_wdata[LEN_W-1:0];
         if (wr_ien) ien_q <= bus_wdata & IRQ_MASK;
         if (wr_wm)  wm_q  <= bus_wdata[WM_W-1:0];
         if (wr_clk) begin
            clk_en_q <= bus_wdata[0];
            div_q    <= bus_wdata[4 +: DIV_W];
         end
         if (wr_iclr) istat_q <= ((istat_q & ~bus_wdata) | irq_set) & IRQ_MASK;
         else         istat_q <= (istat_q | irq_set) & IRQ_MASK;
      end
   end

   assign irq = |(istat_q & ien_q);

   always_comb begin
      bus_rdata = '0;
      case (32'(bus_addr))
         A_CMD:   bus_rdata = cmd_q;
         A_LEN:   bus_rdata = 32'(len_q);
         A_IEN:   bus_rdata = ien_q;
         A_ISTAT: bus_rdata = istat_q;
         A_STAT:  bus_rdata = {31'd0, active_q};
         A_FCNT:  bus_rdata = 32'(fifo_cnt);
         A_WM:    bus_rdata = 32'(wm_q);
         A_CLK:   bus_rdata = 32'({div_q, 3'b000, clk_en_q});
         default: bus_rdata = '0;
      endcase
   end
endmodule

// File: rtl/uatx_checker.sv
module uatx_checker #(
   parameter int unsigned DEPTH = 16,
   parameter int unsigned CNT_W = 5,
   parameter int unsigned WM_W  = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic             wr_abort,
   input logic             stop_any,
   input logic             active,
   input logic             txd,
   input logic [CNT_W-1:0] fifo_cnt,
   input logic [WM_W-1:0]  wm,
   input logic [31:0]      istat
);
   AST_IDLE_LINE_HIGH: assert property (@(posedge clk) disable iff (!rst_n) !active |-> txd); // R2
   AST_DONE_AT_END: assert property (@(posedge clk) disable iff (!rst_n) ($fell(active) && !$past(stop_any)) |-> istat[0]); // R2
   AST_ABORT_FLAG: assert property (@(posedge clk) disable iff (!rst_n) wr_abort |=> istat[5]); // R6
   AST_ABORT_STOPS: assert property (@(posedge clk) disable iff (!rst_n) wr_abort |=> (!active && txd && fifo_cnt == '0)); // R6
   AST_WM_FLAG: assert property (@(posedge clk) disable iff (!rst_n) (32'(fifo_cnt) < 32'(wm)) |=> istat[30]); // R8
   AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n) 32'(fifo_cnt) <= DEPTH); // R11
endmodule

bind uart_tx_seq uatx_checker #(.DEPTH(FIFO_DEPTH), .CNT_W(CNT_W), .WM_W(WM_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .wr_abort(wr_abort), .stop_any(stop_any),
   .active(active_q), .txd(txd), .fifo_cnt(fifo_cnt), .wm(wm_q), .istat(istat_q)
);

// File: tb/tb_uart_tx_seq.sv
module tb_uart_tx_seq;
   import uatx_pkg::*;
   localparam int DEPTH = 16;

   logic        clk = 1'b0, rst_n = 1'b0, bus_wr = 1'b0;
   logic [7:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0, bus_rdata, rv;
   logic        txd, irq;
   int checks = 0, fails = 0, cyc = 0;

   always #5 clk = ~clk;

   uart_tx_seq dut (.clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .txd(txd), .irq(irq));

   // behavioural reference
   logic [7:0]  mq[$];
   logic [31:0] m_cmd, m_en, m_stat, m_set;
   logic [15:0] m_len;
   logic [7:0]  m_wm, m_sh;
   int m_div, m_rem, m_st, m_cnt, m_bit, sz, bitlen;
   bit m_active, m_clk_en, m_txd, stp, abt, cnl, go, psh;

   always @(posedge clk) begin
      if (!rst_n) begin
         mq.delete(); m_cmd = 0; m_en = 0; m_stat = 0; m_len = 0; m_wm = 2;
         m_div = 1; m_clk_en = 1; m_active = 0; m_rem = 0; m_st = 0; m_cnt = 0;
         m_bit = 0; m_sh = 0; m_txd = 1;
      end else begin
         sz = mq.size();
         bitlen = 32 * ((m_div == 0) ? 1 : m_div);
         m_set = 0;
         if (sz < m_wm) m_set[30] = 1;
         stp = bus_wr && bus_addr == A_CTRL && bus_wdata[2:0] != 0;
         abt = stp && bus_wdata[1];
         cnl = stp && bus_wdata[2];
         go  = bus_wr && bus_addr == A_CMD && bus_wdata[31:27] == 5'd1 && !m_active;
         psh = bus_wr && bus_addr == A_TXD && sz < DEPTH;
         if (abt) m_set[5] = 1;
         if (stp) begin
            if (m_active) begin
               if (cnl) m_set[0] = 1;
               m_active = 0; m_st = 0; m_txd = 1; m_cnt = 0;
            end
         end else if (go) begin
            if (m_len == 0) m_set[0] = 1;
            else begin m_active = 1; m_rem = m_len; end
         end else if (m_active) begin
            if (m_st == 0) begin
               if (m_rem == 0) begin m_active = 0; m_set[0] = 1; end
               else if (sz > 0) begin
                  m_sh = mq.pop_front(); m_st = 1; m_txd = 0; m_cnt = 0; m_rem--;
               end
            end else if (m_clk_en) begin
               if (m_cnt == bitlen - 1) begin
                  m_cnt = 0;
                  case (m_st)
                     1: begin m_st = 2; m_bit = 0; m_txd = m_sh[0]; end
                     2: if (m_bit == 7) begin m_st = 3; m_txd = 1; end
                        else begin m_bit++; m_txd = m_sh[m_bit]; end
                     default: m_st = 0;
                  endcase
               end else m_cnt++;
            end
         end
         if (abt) mq.delete();
         else if (psh) mq.push_back(bus_wdata[7:0]);
         if (bus_wr && bus_addr == A_ICLR) m_stat = ((m_stat & ~bus_wdata) | m_set) & IRQ_MASK;
         else m_stat = (m_stat | m_set) & IRQ_MASK;
         if (bus_wr) case (32'(bus_addr))
            A_CMD: m_cmd = bus_wdata;
            A_LEN: m_len = bus_wdata[15:0];
            A_IEN: m_en = bus_wdata & IRQ_MASK;
            A_WM:  m_wm = bus_wdata[7:0];
            A_CLK: begin m_clk_en = bus_wdata[0]; m_div = int'(bus_wdata[15:4]); end
            default: ;
         endcase
      end
   end

   task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FIFO-CHECK FAIL %s at cycle %0d: actual=%h expected=%h", tag, cyc, act, exp);
      end
   endtask

   always @(negedge clk) begin
      if (rst_n) begin
         chk("R3 txd vs model", 32'(txd), 32'(m_txd));
         chk("R10 irq vs model", 32'(irq), 32'(|(m_stat & m_en)));
      end
   end

   always @(posedge clk) begin
      cyc++;
      if (cyc > 150000) begin
         fails++; checks++;
         $display("FAIL watchdog expired at cycle %0d (actual running, expected finished)", cyc);
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   task automatic wr(int a, logic [31:0] d);
      @(negedge clk); bus_wr = 1; bus_addr = 8'(a); bus_wdata = d;
      @(negedge clk); bus_wr = 0;
   endtask

   task automatic rd(int a, output logic [31:0] v);
      @(negedge clk); bus_addr = 8'(a); #1; v = bus_rdata;
   endtask

   task automatic idle(int n);
      repeat (n) @(negedge clk);
   endtask

   initial begin
      int lowlen;
      idle(3); rst_n = 1; idle(2);
      rd(A_STAT, rv); chk("R1 status", rv, 0);
      rd(A_FCNT, rv); chk("R1 fifo count", rv, 0);
      rd(A_WM, rv);   chk("R1 watermark level", rv, 2);
      rd(A_CLK, rv);  chk("R1 clock word", rv, 32'h11);
      rd(A_IEN, rv);  chk("R1 enables", rv, 0);
      chk("R1 line idle", 32'(txd), 1);
      chk("R1 irq low", 32'(irq), 0);

      wr(A_IEN, 32'h4000_0021);
      wr(A_TXD, 32'hA5); wr(A_TXD, 32'h3C); wr(A_LEN, 2); wr(A_CMD, 32'h0800_0000);
      idle(3); rd(A_STAT, rv); chk("R2 active during send", rv, 1);
      idle(700); rd(A_STAT, rv); chk("R2 idle after send", rv, 0);
      rd(A_ISTAT, rv); chk("R2 done flag", rv & 1, 1);
      chk("R10 irq with done enabled", 32'(irq), 1);

      wr(A_ICLR, 1); rd(A_ISTAT, rv); chk("R9 done cleared", rv & 1, 0);
      wr(A_ICLR, 32'h4000_0000); rd(A_ISTAT, rv); chk("R9 watermark set wins", rv >> 30, 1);

      wr(A_TXD, 32'h81); wr(A_LEN, 1); wr(A_CMD, 32'h0800_0000); idle(10);
      wr(A_LEN, 3); wr(A_CMD, 32'h0800_0000);
      idle(400); rd(A_STAT, rv); chk("R5 restart while busy ignored", rv, 0);
      wr(A_CMD, 32'h1000_0000); idle(3); rd(A_STAT, rv); chk("R5 other opcode ignored", rv, 0);

      wr(A_ICLR, 1); wr(A_LEN, 0); wr(A_CMD, 32'h0800_0000);
      rd(A_ISTAT, rv); chk("R12 zero length done", rv & 1, 1);
      rd(A_STAT, rv);  chk("R12 zero length not active", rv, 0);

      wr(A_ICLR, 1); wr(A_LEN, 2); wr(A_CMD, 32'h0800_0000); wr(A_TXD, 32'h55);
      idle(400); rd(A_STAT, rv); chk("R13 waits for data", rv, 1);
      chk("R13 line high while dry", 32'(txd), 1);
      rd(A_ISTAT, rv); chk("R13 no done while dry", rv & 1, 0);
      wr(A_TXD, 32'hAA); idle(400);
      rd(A_STAT, rv); chk("R13 resumes and ends", rv, 0);

      wr(A_ICLR, 32'h21);
      wr(A_TXD, 1); wr(A_TXD, 2); wr(A_TXD, 3); wr(A_LEN, 3); wr(A_CMD, 32'h0800_0000);
      idle(100); wr(A_CTRL, 2);
      chk("R6 line high after abort", 32'(txd), 1);
      rd(A_STAT, rv);  chk("R6 not active", rv, 0);
      rd(A_FCNT, rv);  chk("R6 fifo flushed", rv, 0);
      rd(A_ISTAT, rv); chk("R6 abort flag", (rv >> 5) & 1, 1);

      wr(A_ICLR, 32'h21); wr(A_TXD, 7); wr(A_LEN, 1); wr(A_CMD, 32'h0800_0000);
      idle(50); wr(A_CTRL, 4);
      rd(A_STAT, rv);  chk("R7 cancel stops", rv, 0);
      rd(A_ISTAT, rv); chk("R7 cancel sets done", rv & 32'h21, 1);
      wr(A_ICLR, 32'h21); wr(A_TXD, 9); wr(A_LEN, 1); wr(A_CMD, 32'h0800_0000);
      idle(50); wr(A_CTRL, 1);
      rd(A_STAT, rv);  chk("R7 disable stops", rv, 0);
      rd(A_ISTAT, rv); chk("R7 disable raises nothing", rv & 32'h21, 0);
      chk("R7 line high after disable", 32'(txd), 1);

      for (int i = 0; i < DEPTH + 3; i++) wr(A_TXD, 32'(i));
      rd(A_FCNT, rv); chk("R11 overflow dropped", rv, DEPTH);
      wr(A_ICLR, 32'h4000_0000); idle(2);
      rd(A_ISTAT, rv); chk("R8 no watermark when full", rv >> 30, 0);
      wr(A_WM, 32); idle(2);
      rd(A_ISTAT, rv); chk("R8 watermark below level", rv >> 30, 1);
      wr(A_CTRL, 2); wr(A_WM, 2); wr(A_ICLR, 32'h21);

      wr(A_TXD, 0); wr(A_LEN, 1); wr(A_CMD, 32'h0800_0000);
      lowlen = 0;
      for (int i = 0; i < 20 && txd; i++) idle(1);
      while (!txd && lowlen < 1000) begin idle(1); lowlen++; end
      chk("R3 nine low bits of 32 clocks", 32'(lowlen), 288);
      idle(100);

      wr(A_CLK, 32'h21); wr(A_TXD, 32'hC3); wr(A_LEN, 1); wr(A_CMD, 32'h0800_0000);
      idle(100); wr(A_CLK, 32'h20); idle(800);
      rd(A_STAT, rv); chk("R4 frozen while disabled", rv, 1);
      wr(A_CLK, 32'h21); idle(700);
      rd(A_STAT, rv); chk("R3 divider two frame complete", rv, 0);
      rd(A_CLK, rv);  chk("R3 clock word readback", rv, 32'h21);

      idle(5);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule